// File: doc/BRIEF.md
# Flash Array Block Protection Controller

This block keeps the protection settings that decide which slice of a flash main array is shielded from program and erase operations. For each program or erase request, it gives a one-cycle verdict: the request is either granted or denied. A three-bit protect code sets the size of the shielded slice. A direction bit anchors that slice either at the top of the address space or at address zero.

The protect code exists in two copies. One is a retained (nonvolatile) copy and the other is a working (volatile) copy. A source-select bit chooses which copy governs. That bit also sets how register writes and reset events update each copy. Once the first program or erase has been granted, a retained lock flag freezes the direction bit. Retained storage is modelled as registers that only the power-on reset `rst_n` clears, which gives the factory state. Hardware and software reset events arrive as synchronous pulses. These events reload only the working copy.

Top module: `fprot_ctrl`

## Requirements
- R1: After power-on reset, `bp_o` reads 000, `dir_o` reads 0, and neither `grant_o` nor `deny_o` is asserted.
- R2: With array size S = 2^ADDR_W, the size of the protected slice depends on the code, with code 0 giving no protection:

  | Code | Protected size |
  |------|----------------|
  | 000 | none |
  | 001 | S/64 |
  | 010 | S/32 |
  | 011 | S/16 |
  | 100 | S/8 |
  | 101 | S/4 |
  | 110 | S/2 (with default ADDR_W = 26, exactly half) |
  | 111 | all of S |
- R3: With `dir_o` = 0, an address is protected when it is greater than or equal to S minus the protected size.
- R4: With `dir_o` = 1, an address is protected when it is less than the protected size.
- R5: With source select at 0, a register write (`wrr_en`) stores `wrr_bp` into both copies, and `bp_o` shows the retained copy.
- R6: With source select at 1, a register write stores into the working copy only, `bp_o` shows the working copy, and the retained copy keeps its value.
- R7: A hardware or software reset event with source select at 0 copies the retained code into the working copy.
- R8: A hardware or software reset event with source select at 1 forces the working copy to 111, so every address is denied. A reset event takes priority over a register write in the same cycle.
- R9: A request sampled at a clock edge produces, one cycle later, exactly one of two single-cycle pulses: `deny_o` when the address is protected, otherwise `grant_o`. Neither pulse appears without a request.
- R10: `cfg_en` loads `cfg_mode` in all cases. It loads `cfg_dir` only until the first granted request. After that, `dir_o` holds its value through later configuration writes and through hardware or software reset events.
- R11: Denied requests do not set the lock on the direction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low; sets the factory state |
| wrr_en | input | 1 | Register write strobe for the protect code |
| wrr_bp | input | 3 | New protect code |
| cfg_en | input | 1 | Configuration write strobe |
| cfg_mode | input | 1 | New source select (0 retained, 1 working) |
| cfg_dir | input | 1 | New direction (0 top, 1 bottom) |
| hw_rst | input | 1 | Hardware reset event pulse |
| sw_rst | input | 1 | Software reset event pulse |
| req_valid | input | 1 | Program or erase request strobe |
| req_addr | input | ADDR_W | Request address |
| bp_o | output | 3 | Governing protect code |
| dir_o | output | 1 | Direction bit |
| grant_o | output | 1 | Request allowed pulse |
| deny_o | output | 1 | Request rejected pulse |

## Verification
The assertions take the strobes as clean single-cycle synchronous pulses sampled at the rising edge. They also assume `rst_n` is used only as a factory power-on reset, since the lock flag and the retained copy are checked for stability everywhere except across that reset. The bench drives every strobe on the falling edge and holds each one for exactly one cycle. It returns to the factory state with `rst_n` whenever a scenario needs an unlocked direction bit, and it never issues a request in the same cycle as a write to the register or configuration it depends on.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  localparam int BP_W = 3;
  typedef logic [BP_W-1:0] bp_t;
  localparam bp_t BP_NONE = 3'b000;
  localparam bp_t BP_ALL  = 3'b111;
  localparam int  N_CODES = 1 << BP_W;
endpackage

// File: rtl/fprot_regs.sv
module fprot_regs
  import fprot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  bp_t  wr_bp,
  input  logic cfg_en,
  input  logic cfg_mode,
  input  logic cfg_dir,
  input  logic reload,
  input  logic op_granted,
  output bp_t  bp_act,
  output logic dir,
  output logic locked
);
  bp_t  nv_q, nv_d, vol_q, vol_d;
  logic mode_q, mode_d;
  logic dir_q, dir_d;
  logic lock_q, lock_d;

  always_comb begin
    nv_d   = nv_q;
    vol_d  = vol_q;
    mode_d = mode_q;
    dir_d  = dir_q;
    lock_d = lock_q;
    if (cfg_en) begin
      mode_d = cfg_mode;
      if (!lock_q) dir_d = cfg_dir;
    end
    if (reload) begin
      vol_d = mode_q ? BP_ALL : nv_q;
    end else if (wr_en) begin
      vol_d = wr_bp;
      if (!mode_q) nv_d = wr_bp;
    end
    if (op_granted) lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q   <= BP_NONE;
      vol_q  <= BP_NONE;
      mode_q <= 1'b0;
      dir_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      nv_q   <= nv_d;
      vol_q  <= vol_d;
      mode_q <= mode_d;
      dir_q  <= dir_d;
      lock_q <= lock_d;
    end
  end

  assign bp_act = mode_q ? vol_q : nv_q;
  assign dir    = dir_q;
  assign locked = lock_q;

  // R10
  dir_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(dir_q));
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R6
  nv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_q) |=> $stable(nv_q));
  // R7
  reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !mode_q) |=> (vol_q == $past(nv_q)));
  // R8
  reload_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && mode_q) |=> (vol_q == BP_ALL));
endmodule

// File: rtl/fprot_range.sv
module fprot_range
  import fprot_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  bp_t               bp,
  input  logic              dir,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int SW = ADDR_W + 1;
  localparam logic [SW-1:0] ARRAY_SZ = {1'b1, {ADDR_W{1'b0}}};

  logic [SW-1:0] size_tbl [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_size
    if (g == 0) begin : g_none
      assign size_tbl[g] = '0;
    end else begin : g_frac
      assign size_tbl[g] = ARRAY_SZ >> (N_CODES - 1 - g);
    end
  end

  logic [SW-1:0] psize, addr_x, top_floor;

  always_comb begin
    psize     = size_tbl[bp];
    addr_x    = {1'b0, addr};
    top_floor = ARRAY_SZ - psize;
    if (dir) hit = addr_x < psize;
    else     hit = addr_x >= top_floor;
  end
endmodule

// File: rtl/fprot_gate.sv
module fprot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  output logic grant_o,
  output logic deny_o
);
  logic grant_d, deny_d;

  always_comb begin
    grant_d = req_valid && !hit;
    deny_d  = req_valid && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      grant_o <= grant_d;
      deny_o  <= deny_d;
    end
  end

  // R9
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && deny_o));
  // R9
  answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant_o || deny_o));
  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant_o && !deny_o));
endmodule

// File: rtl/fprot_ctrl.sv
module fprot_ctrl
  import fprot_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrr_en,
  input  logic [2:0]        wrr_bp,
  input  logic              cfg_en,
  input  logic              cfg_mode,
  input  logic              cfg_dir,
  input  logic              hw_rst,
  input  logic              sw_rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        bp_o,
  output logic              dir_o,
  output logic              grant_o,
  output logic              deny_o
);
  bp_t  bp_act;
  logic dir, locked, hit, reload;

  assign reload = hw_rst || sw_rst;

  fprot_regs i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wrr_en), .wr_bp(wrr_bp),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
    .reload(reload), .op_granted(grant_o),
    .bp_act(bp_act), .dir(dir), .locked(locked)
  );

  fprot_range #(.ADDR_W(ADDR_W)) i_range (
    .bp(bp_act), .dir(dir), .addr(req_addr), .hit(hit)
  );

  fprot_gate i_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit),
    .grant_o(grant_o), .deny_o(deny_o)
  );

  assign bp_o  = bp_act;
  assign dir_o = dir;

  // R2
  full_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bp_act == BP_ALL) |=> deny_o);
  // R11
  deny_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && deny_o) |=> !locked);
  // R10
  grant_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> locked);
endmodule

// File: tb/test_fprot_ctrl.sv
`timescale 1ns/1ps
module test_fprot_ctrl;
  localparam int AW = 26;
  localparam longint SZ = longint'(1) << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic wrr_en, cfg_en, cfg_mode, cfg_dir, hw_rst, sw_rst, req_valid;
  logic [2:0] wrr_bp;
  logic [AW-1:0] req_addr;
  logic [2:0] bp_o;
  logic dir_o, grant_o, deny_o;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fprot_ctrl #(.ADDR_W(AW)) i_fprot_ctrl (
    .clk(clk), .rst_n(rst_n), .wrr_en(wrr_en), .wrr_bp(wrr_bp),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
    .hw_rst(hw_rst), .sw_rst(sw_rst), .req_valid(req_valid),
    .req_addr(req_addr), .bp_o(bp_o), .dir_o(dir_o),
    .grant_o(grant_o), .deny_o(deny_o)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint psz(int code);
    case (code)
      1: return SZ / 64;
      2: return SZ / 32;
      3: return SZ / 16;
      4: return SZ / 8;
      5: return SZ / 4;
      6: return SZ / 2;
      7: return SZ;
      default: return 0;
    endcase
  endfunction

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; wrr_en = 0; wrr_bp = 0; cfg_en = 0; cfg_mode = 0;
    cfg_dir = 0; hw_rst = 0; sw_rst = 0; req_valid = 0; req_addr = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wrr(logic [2:0] code);
    @(negedge clk); wrr_en = 1; wrr_bp = code;
    @(negedge clk); wrr_en = 0;
  endtask

  task automatic cfg(logic m, logic d);
    @(negedge clk); cfg_en = 1; cfg_mode = m; cfg_dir = d;
    @(negedge clk); cfg_en = 0;
  endtask

  task automatic evt(logic hw);
    @(negedge clk); hw_rst = hw; sw_rst = !hw;
    @(negedge clk); hw_rst = 0; sw_rst = 0;
  endtask

  task automatic req(longint addr, bit exp_deny, string tag);
    @(negedge clk); req_valid = 1; req_addr = addr[AW-1:0];
    @(negedge clk); req_valid = 0;
    chk({tag, " deny"}, deny_o, exp_deny);
    chk({tag, " grant"}, grant_o, !exp_deny);
    @(negedge clk);
    chk("R9 pulse ends", {grant_o, deny_o}, 0);
  endtask

  task automatic t_reset();
    por();
    chk("R1 bp", bp_o, 0);
    chk("R1 dir", dir_o, 0);
    chk("R1 verdicts", {grant_o, deny_o}, 0);
  endtask

  task automatic t_top();
    por();
    req(SZ - 1, 0, "R2 code0 top end");
    for (int c = 1; c < 8; c++) begin
      wrr(c[2:0]);
      chk("R5 bp shown", bp_o, c);
      req(SZ - psz(c), 1, "R3 top floor");
      if (psz(c) < SZ) req(SZ - psz(c) - 1, 0, "R3 below floor");
      else req(0, 1, "R2 whole array");
    end
  endtask

  task automatic t_bottom();
    por();
    cfg(0, 1);
    chk("R10 dir writable", dir_o, 1);
    for (int c = 1; c < 7; c++) begin
      wrr(c[2:0]);
      req(psz(c) - 1, 1, "R4 below ceiling");
      req(psz(c), 0, "R4 at ceiling");
    end
    req(33554431, 1, "R2 half lower");
    req(33554432, 0, "R2 half upper");
  endtask

  task automatic t_modes();
    por();
    wrr(3'b011);
    cfg(1, 0);
    chk("R5 copied to working", bp_o, 3);
    wrr(3'b010);
    chk("R6 working written", bp_o, 2);
    cfg(0, 0);
    chk("R6 retained unchanged", bp_o, 3);
    evt(1);
    cfg(1, 0);
    chk("R7 reload copy", bp_o, 3);
    evt(0);
    chk("R8 forced all", bp_o, 7);
    req(0, 1, "R8 addr0 denied");
    @(negedge clk); sw_rst = 1; wrr_en = 1; wrr_bp = 3'b001;
    @(negedge clk); sw_rst = 0; wrr_en = 0;
    chk("R8 reset beats write", bp_o, 7);
  endtask

  task automatic t_lock();
    por();
    wrr(3'b111);
    req(5, 1, "R11 denied");
    cfg(0, 1);
    chk("R11 dir still writable", dir_o, 1);
    cfg(0, 0);
    chk("R11 dir back", dir_o, 0);
    wrr(3'b000);
    req(5, 0, "R10 grant");
    cfg(0, 1);
    chk("R10 dir locked", dir_o, 0);
    evt(1);
    evt(0);
    cfg(0, 1);
    chk("R10 lock survives reset events", dir_o, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_top();
    t_bottom();
    t_modes();
    t_lock();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule